// File: doc/BRIEF.md
# Tiled Edit-Distance Compute Unit

This block evaluates one square tile of the Levenshtein dynamic-programming matrix. A host, or a neighbouring unit, streams in TILE characters of each string and the edges around the tile: the column to its left, the row above it and the single value at its upper-left corner. The unit then produces its own right column, bottom row and lower-right corner, which are exactly the edges the tiles to its right, below and diagonal need. Chaining many units in this way lets a large matrix be swept as a wavefront of tiles.

Inside a tile one row engine per string-A character works along anti-diagonals, so a TILE x TILE tile finishes in 2*TILE-1 compute cycles. Each row engine holds only its latest value and the one before it. When the tile touches the top row or the left column of the full matrix, the unit makes those boundary values itself from the tile's global origin and discards the matching edge input. A one-cycle done pulse closes each tile once the last output beat has been taken.

Top module: `edit_tile`

## Requirements
- R1: Every cell equals the minimum of its left neighbour plus 1, its upper neighbour plus 1, and its diagonal neighbour plus a substitution cost that is 0 when the row's A character equals the column's B character and 1 otherwise; the whole tile is computed from the stored characters and edges by this rule.
- R2: The character stream takes TILE beats; beat k (counting from 0) gives the A character of tile row k+1 on `chr_a` and the B character of tile column k+1 on `chr_b`; a beat is taken on a clock edge where `chr_valid` and `chr_ready` are both high.
- R3: The edge stream takes TILE beats; beat k gives the left-edge value of tile row k+1 on `edg_left` and the top-edge value of tile column k+1 on `edg_top`; `edg_corner` is taken with beat 0 and is the upper-left corner value.
- R4: The two input streams are taken independently in any interleaving; each ready drops after its TILE beats and stays low until the tile has been emitted, and neither is high while output beats are offered.
- R5: When `row_org` is 0 the top edge becomes col_org+k+1 for column k+1 and the corner becomes `col_org`; the top and corner inputs are ignored.
- R6: When `col_org` is 0 (and `row_org` is not) the left edge becomes row_org+k+1 for row k+1 and the corner becomes `row_org`; the left and corner inputs are ignored. `row_org` and `col_org` are sampled on the edge that takes the final input beat.
- R7: `out_valid` is first high 15 clock edges (2*TILE-1) after the edge that took the final input beat.
- R8: The output stream gives TILE beats; beat k carries the tile's right-column value of row k+1 on `out_p`, the bottom-row value of column k+1 on `out_q`, and the lower-right corner on `out_corner`; values hold while `out_ready` is low.
- R9: `done` is high for exactly the one cycle after the edge that takes the final output beat, and from that same cycle both input readies are high again.
- R10: After reset both input readies are high, and `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_org | input | DW | Global row index of the tile's upper-left corner |
| col_org | input | DW | Global column index of the tile's upper-left corner |
| chr_valid | input | 1 | Character beat offered |
| chr_ready | output | 1 | Character beat can be taken |
| chr_a | input | CW | String A character for this beat |
| chr_b | input | CW | String B character for this beat |
| edg_valid | input | 1 | Edge beat offered |
| edg_ready | output | 1 | Edge beat can be taken |
| edg_left | input | DW | Left-edge value for this beat |
| edg_top | input | DW | Top-edge value for this beat |
| edg_corner | input | DW | Upper-left corner, taken with beat 0 |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Output beat taken |
| out_p | output | DW | Right-column value for this beat |
| out_q | output | DW | Bottom-row value for this beat |
| out_corner | output | DW | Lower-right corner value |
| done | output | 1 | One-cycle end-of-tile pulse |

## Verification
The start of computation can coincide with the last beat of either input stream, or with both landing on one edge, so the two loaders' completion is the shared event to stress. The bench runs tiles where both streams advance in lockstep and ends them on the same edge, and tiles where the edge stream starts late so that the character stream finishes first and its ready must stay low while the other catches up. In both cases the latency from the later final beat to the first output beat is counted in clock cycles and the emitted edges are compared with an independent matrix model.

// File: rtl/edt_pkg.sv
package edt_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_CALC = 2'd1,
        ST_EMIT = 2'd2
    } edt_state_e;

endpackage

// File: rtl/edt_cell.sv
module edt_cell #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic [CW-1:0] ch_a,
    input  logic [CW-1:0] ch_b,
    input  logic [DW-1:0] left,
    input  logic [DW-1:0] up,
    input  logic [DW-1:0] diag,
    output logic [DW-1:0] res
);

    logic [DW-1:0] via_diag;
    logic [DW-1:0] via_left;
    logic [DW-1:0] via_up;
    logic [DW-1:0] best_lu;

    always_comb begin
        via_diag = diag + {{(DW-1){1'b0}}, (ch_a != ch_b)};
        via_left = left + 1'b1;
        via_up   = up + 1'b1;
        best_lu  = (via_left < via_up) ? via_left : via_up;
        res      = (via_diag < best_lu) ? via_diag : best_lu;
    end

endmodule

// File: rtl/edt_row.sv
module edt_row #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic [CW-1:0] ch_a,
    input  logic [CW-1:0] ch_b,
    input  logic [DW-1:0] left,
    input  logic [DW-1:0] up,
    input  logic [DW-1:0] diag,
    output logic [DW-1:0] cur,
    output logic [DW-1:0] prev,
    output logic [DW-1:0] nxt
);

    typedef struct packed {
        logic [DW-1:0] cur;
        logic [DW-1:0] prev;
    } row_t;

    row_t row_d, row_q;

    edt_cell #(.DW(DW), .CW(CW)) u_cell (
        .ch_a (ch_a),
        .ch_b (ch_b),
        .left (left),
        .up   (up),
        .diag (diag),
        .res  (nxt)
    );

    always_comb begin
        row_d = row_q;
        if (act) begin
            row_d.cur  = nxt;
            row_d.prev = row_q.cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign cur  = row_q.cur;
    assign prev = row_q.prev;

    // R1: a computed cell never exceeds any of its three candidates
    assert_cell_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> ({1'b0, cur} <= {1'b0, $past(left)} + 1'b1) &&
                ({1'b0, cur} <= {1'b0, $past(up)} + 1'b1) &&
                ({1'b0, cur} <= {1'b0, $past(diag)} + 1'b1));

    // R1: on a character match the cell is no larger than its diagonal
    assert_match_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (act && (ch_a == ch_b)) |=> (cur <= $past(diag)));

endmodule

// File: rtl/edit_tile.sv
module edit_tile
    import edt_pkg::*;
#(
    parameter int TILE = 8,
    parameter int DW   = 16,
    parameter int CW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] row_org,
    input  logic [DW-1:0] col_org,
    input  logic          chr_valid,
    output logic          chr_ready,
    input  logic [CW-1:0] chr_a,
    input  logic [CW-1:0] chr_b,
    input  logic          edg_valid,
    output logic          edg_ready,
    input  logic [DW-1:0] edg_left,
    input  logic [DW-1:0] edg_top,
    input  logic [DW-1:0] edg_corner,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_p,
    output logic [DW-1:0] out_q,
    output logic [DW-1:0] out_corner,
    output logic          done
);

    localparam int CNTW  = $clog2(TILE + 1);
    localparam int IDXW  = $clog2(TILE);
    localparam int STEPS = 2 * TILE - 1;
    localparam int STW   = $clog2(STEPS + 1);
    localparam logic [CNTW-1:0] FULL      = CNTW'(TILE);
    localparam logic [CNTW-1:0] LAST_BEAT = CNTW'(TILE - 1);
    localparam logic [STW-1:0]  LAST_STEP = STW'(STEPS - 1);

    typedef struct packed {
        edt_state_e                  st;
        logic [CNTW-1:0]             ca_cnt;
        logic [CNTW-1:0]             ed_cnt;
        logic [CNTW-1:0]             out_cnt;
        logic [STW-1:0]              step;
        logic [TILE-1:0][CW-1:0]     a_chr;
        logic [TILE-1:0][CW-1:0]     b_chr;
        logic [TILE-1:0][DW-1:0]     left_e;
        logic [TILE-1:0][DW-1:0]     top_e;
        logic [TILE-1:0][DW-1:0]     bot;
        logic [DW-1:0]               corner;
        logic                        done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TILE-1:0][DW-1:0] row_cur;
    logic [TILE-1:0][DW-1:0] row_prev;
    logic [TILE-1:0][DW-1:0] row_nxt;
    logic [TILE-1:0]         row_act;

    for (genvar i = 0; i < TILE; i++) begin : g_row
        int              jj;
        logic            act_l;
        logic [IDXW-1:0] jidx;
        logic [IDXW-1:0] jm1;
        logic [DW-1:0]   lft;
        logic [DW-1:0]   upv;
        logic [DW-1:0]   dgv;

        always_comb begin
            jj    = int'(ctl_q.step) - i;
            act_l = (ctl_q.st == ST_CALC) && (jj >= 0) && (jj < TILE);
            jidx  = act_l ? jj[IDXW-1:0] : '0;
            jm1   = jidx - 1'b1;
            lft   = (jj == 0) ? ctl_q.left_e[i] : row_cur[i];
        end

        if (i == 0) begin : g_top
            always_comb begin
                upv = ctl_q.top_e[jidx];
                dgv = (jj == 0) ? ctl_q.corner : ctl_q.top_e[jm1];
            end
        end else begin : g_inner
            always_comb begin
                upv = row_cur[i-1];
                dgv = (jj == 0) ? ctl_q.left_e[i-1] : row_prev[i-1];
            end
        end

        assign row_act[i] = act_l;

        edt_row #(.DW(DW), .CW(CW)) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (act_l),
            .ch_a  (ctl_q.a_chr[i]),
            .ch_b  (ctl_q.b_chr[jidx]),
            .left  (lft),
            .up    (upv),
            .diag  (dgv),
            .cur   (row_cur[i]),
            .prev  (row_prev[i]),
            .nxt   (row_nxt[i])
        );
    end

    logic [IDXW-1:0] ca_idx, ed_idx, out_idx;
    assign ca_idx  = ctl_q.ca_cnt[IDXW-1:0];
    assign ed_idx  = ctl_q.ed_cnt[IDXW-1:0];
    assign out_idx = ctl_q.out_cnt[IDXW-1:0];

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_LOAD: begin
                if (chr_valid && chr_ready) begin
                    ctl_d.a_chr[ca_idx] = chr_a;
                    ctl_d.b_chr[ca_idx] = chr_b;
                    ctl_d.ca_cnt        = ctl_q.ca_cnt + 1'b1;
                end
                if (edg_valid && edg_ready) begin
                    ctl_d.left_e[ed_idx] = edg_left;
                    ctl_d.top_e[ed_idx]  = edg_top;
                    if (ctl_q.ed_cnt == '0) ctl_d.corner = edg_corner;
                    ctl_d.ed_cnt = ctl_q.ed_cnt + 1'b1;
                end
                if ((ctl_d.ca_cnt == FULL) && (ctl_d.ed_cnt == FULL)) begin
                    ctl_d.st   = ST_CALC;
                    ctl_d.step = '0;
                    for (int k = 0; k < TILE; k++) begin
                        if (row_org == '0) ctl_d.top_e[k]  = col_org + DW'(k + 1);
                        if (col_org == '0) ctl_d.left_e[k] = row_org + DW'(k + 1);
                    end
                    if (row_org == '0)      ctl_d.corner = col_org;
                    else if (col_org == '0) ctl_d.corner = row_org;
                end
            end
            ST_CALC: begin
                if (row_act[TILE-1]) ctl_d.bot = {row_nxt[TILE-1], ctl_q.bot[TILE-1:1]};
                ctl_d.step = ctl_q.step + 1'b1;
                if (ctl_q.step == LAST_STEP) begin
                    ctl_d.st      = ST_EMIT;
                    ctl_d.out_cnt = '0;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    ctl_d.out_cnt = ctl_q.out_cnt + 1'b1;
                    if (ctl_q.out_cnt == LAST_BEAT) begin
                        ctl_d.st     = ST_LOAD;
                        ctl_d.ca_cnt = '0;
                        ctl_d.ed_cnt = '0;
                        ctl_d.done   = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign chr_ready  = (ctl_q.st == ST_LOAD) && (ctl_q.ca_cnt != FULL);
    assign edg_ready  = (ctl_q.st == ST_LOAD) && (ctl_q.ed_cnt != FULL);
    assign out_valid  = (ctl_q.st == ST_EMIT);
    assign out_p      = row_cur[out_idx];
    assign out_q      = ctl_q.bot[out_idx];
    assign out_corner = row_cur[TILE-1];
    assign done       = ctl_q.done;

    // R9: the end-of-tile pulse lasts a single cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the pulse only follows a taken output beat
    assert_done_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready));

    // R8: a stalled output beat keeps its values
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_p) &&
                                       $stable(out_q) && $stable(out_corner)));

    // R4: no input is taken while results are being offered
    assert_no_load_in_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!chr_ready && !edg_ready));

endmodule

// File: tb/tb_edit_tile.sv
module tb_edit_tile;

    localparam int TILE = 8;
    localparam int DW   = 16;
    localparam int CW   = 8;
    localparam int NV   = 7;

    // fields: A string, B string, row_org, col_org, hand-derived corner (FFFF = model only)
    localparam logic [175:0] VECS [NV] = '{
        {"ABCDEFGH", "ABCDEFGH", 16'd0, 16'd0,  16'd0},
        {"aaaaaaaa", "bbbbbbbb", 16'd0, 16'd0,  16'd8},
        {"ABCDEFGH", "BCDEFGHX", 16'd0, 16'd0,  16'd2},
        {"AAAAAAAA", "AAAAAAAB", 16'd0, 16'd0,  16'd1},
        {"GATTACAG", "CATGACTA", 16'd0, 16'd16, 16'hFFFF},
        {"SITTINGS", "KITTENSS", 16'd8, 16'd0,  16'hFFFF},
        {"ABABABAB", "BABABABA", 16'd8, 16'd8,  16'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] row_org = '0, col_org = '0;
    logic          chr_valid = 1'b0;
    logic          chr_ready;
    logic [CW-1:0] chr_a = '0, chr_b = '0;
    logic          edg_valid = 1'b0;
    logic          edg_ready;
    logic [DW-1:0] edg_left = '0, edg_top = '0, edg_corner = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_p, out_q, out_corner;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [CW-1:0] ta [TILE];
    logic [CW-1:0] tb [TILE];
    logic [DW-1:0] rl [TILE];
    logic [DW-1:0] rt [TILE];
    logic [DW-1:0] rc;
    int            exp_p [TILE];
    int            exp_q [TILE];
    int            exp_c;
    int            acc_chr, acc_edg;
    bit            stagger;

    edit_tile #(.TILE(TILE), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .row_org(row_org), .col_org(col_org),
        .chr_valid(chr_valid), .chr_ready(chr_ready), .chr_a(chr_a), .chr_b(chr_b),
        .edg_valid(edg_valid), .edg_ready(edg_ready), .edg_left(edg_left),
        .edg_top(edg_top), .edg_corner(edg_corner),
        .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p), .out_q(out_q),
        .out_corner(out_corner), .done(done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // independent matrix model built from R1, R5 and R6
    task automatic model(input int ro, input int co);
        int m [TILE+1][TILE+1];
        int cst, c1, c2, c3;
        m[0][0] = (ro == 0) ? co : ((co == 0) ? ro : int'(rc));
        for (int k = 0; k < TILE; k++) begin
            m[0][k+1] = (ro == 0) ? co + k + 1 : int'(rt[k]);
            m[k+1][0] = (co == 0 && ro != 0) ? ro + k + 1 :
                        ((co == 0) ? k + 1 : int'(rl[k]));
        end
        for (int i = 1; i <= TILE; i++) begin
            for (int j = 1; j <= TILE; j++) begin
                cst = (ta[i-1] == tb[j-1]) ? 0 : 1;
                c1 = m[i-1][j-1] + cst;
                c2 = m[i][j-1] + 1;
                c3 = m[i-1][j] + 1;
                m[i][j] = (c1 < c2) ? ((c1 < c3) ? c1 : c3) : ((c2 < c3) ? c2 : c3);
            end
        end
        for (int k = 0; k < TILE; k++) begin
            exp_p[k] = m[k+1][TILE];
            exp_q[k] = m[TILE][k+1];
        end
        exp_c = m[TILE][TILE];
    endtask

    task automatic drive_chr();
        for (int k = 0; k < TILE; k++) begin
            @(negedge clk);
            chr_valid = 1'b1; chr_a = ta[k]; chr_b = tb[k];
            while (!chr_ready) @(negedge clk);
            acc_chr = cyc;
            @(posedge clk);
        end
        @(negedge clk);
        chr_valid = 1'b0;
        if (stagger) check(chr_ready == 1'b0, "R4", "chr_ready after full stream",
                           int'(chr_ready), 0);
    endtask

    task automatic drive_edg();
        if (stagger) repeat (5) @(negedge clk);
        for (int k = 0; k < TILE; k++) begin
            @(negedge clk);
            edg_valid = 1'b1; edg_left = rl[k]; edg_top = rt[k];
            edg_corner = (k == 0) ? rc : 16'h5A5A;
            while (!edg_ready) @(negedge clk);
            acc_edg = cyc;
            @(posedge clk);
        end
        @(negedge clk);
        edg_valid = 1'b0;
    endtask

    task automatic run_vec(input int v);
        logic [63:0] aw, bw;
        int ro, co, hand, beat, last_acc, guard, tag_p, tag_q, tag_c;
        bit stall, held;
        logic [DW-1:0] hp, hq, hc;
        string rq;
        aw = VECS[v][175:112]; bw = VECS[v][111:48];
        ro = int'(VECS[v][47:32]); co = int'(VECS[v][31:16]); hand = int'(VECS[v][15:0]);
        stagger = (v % 2) == 1;
        stall   = (v % 3) == 1;
        for (int k = 0; k < TILE; k++) begin
            ta[k] = aw[8*(TILE-1-k) +: 8];
            tb[k] = bw[8*(TILE-1-k) +: 8];
            if (ro != 0 && co != 0) begin
                rl[k] = DW'(ro + k + 1 + 3);
                rt[k] = DW'(co + k + 1 + 2);
            end else begin
                rl[k] = DW'(16'hBEEF + k);
                rt[k] = DW'(16'hBE00 + k);
            end
        end
        rc = (ro != 0 && co != 0) ? DW'(ro + 1) : 16'h7777;
        rq = (ro == 0 && co != 0) ? "R5" : ((co == 0 && ro != 0) ? "R6" :
             ((ro != 0) ? "R3" : "R2"));
        row_org = DW'(ro); col_org = DW'(co);
        model(ro, co);
        fork
            drive_chr();
            drive_edg();
        join
        last_acc = (acc_chr > acc_edg) ? acc_chr : acc_edg;
        guard = 0;
        while (!out_valid && guard < 100) begin @(negedge clk); guard++; end
        // sampled at negedges: 15 edges after the accepting edge reads as 16
        check(cyc - last_acc == 16, "R7", "compute latency", cyc - last_acc - 1, 15);
        if (hand != 16'hFFFF)
            check(out_corner == DW'(hand), "R1", "hand corner", int'(out_corner), hand);
        beat = 0; held = 1'b0;
        while (beat < TILE) begin
            if (held) begin
                check(out_p == hp && out_q == hq && out_corner == hc, "R8",
                      "stalled beat held", int'(out_p), int'(hp));
                held = 1'b0;
            end
            out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (out_valid && out_ready) begin
                tag_p = int'(out_p); tag_q = int'(out_q); tag_c = int'(out_corner);
                check(tag_p == exp_p[beat], rq, $sformatf("R8 p beat %0d", beat), tag_p, exp_p[beat]);
                check(tag_q == exp_q[beat], rq, $sformatf("R8 q beat %0d", beat), tag_q, exp_q[beat]);
                if (beat == 0) check(tag_c == exp_c, rq, "R1 corner", tag_c, exp_c);
                check(done == 1'b0, "R9", "done during emit", int'(done), 0);
                beat++;
            end else if (out_valid) begin
                hp = out_p; hq = out_q; hc = out_corner; held = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(done == 1'b1, "R9", "done after last beat", int'(done), 1);
        check(chr_ready && edg_ready, "R9", "readies back", int'(chr_ready && edg_ready), 1);
        @(negedge clk);
        check(done == 1'b0, "R9", "done one cycle", int'(done), 0);
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog run did not end actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(chr_ready == 1'b1, "R10", "chr_ready reset", int'(chr_ready), 1);
        check(edg_ready == 1'b1, "R10", "edg_ready reset", int'(edg_ready), 1);
        check(out_valid == 1'b0, "R10", "out_valid reset", int'(out_valid), 0);
        check(done == 1'b0, "R10", "done reset", int'(done), 0);
        for (int v = 0; v < NV; v++) run_vec(v);
        // back-to-back tile with no gap after done
        run_vec(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule